// File: doc/BRIEF.md
# Deferred-Operand Branch Decision Unit

This block decides whether a conditional branch is taken, and where it goes, without keeping any flag bits. Each time the datapath performs an add, a subtract or an add-immediate, it pulses a capture strobe and presents the two values fed to its adder. The block stores these values. A subtract presents its right operand already negated, and an add-immediate presents the extended immediate. When a branch later executes, the block derives the requested relation from the stored pair.

The branch strobe comes with a 4-bit condition code, an 8-bit signed displacement and the program counter that has already been advanced past the branch. One clock later the block reports whether the branch is taken, the destination address and the number of extra cycles the branch costs. The adder that produces the captured values is outside this block.

Top module: `brc_unit`

## Requirements
- R1: When `cap_en` is high at a rising clock edge, `cap_a` and `cap_b` are stored as the operand pair A and B. The pair holds its value while `cap_en` is low, and a synchronous reset clears both to zero.
- R2: Condition bits [3:1] select the relation: 0 always, 1 equal (A equals the 16-bit negation of B), 2 carry, 3 overflow, 4 signed less-than, 5 signed less-or-equal, 6 unsigned less-than, 7 unsigned less-or-equal.
- R3: The carry relation is true exactly when the 16-bit wrapped sum A+B is smaller than A or smaller than B.
- R4: The overflow relation is true exactly when A and B have the same sign bit and the sign bit of the 16-bit sum A+B differs from it.
- R5: The signed relations compare A with the 16-bit negation of B, both taken as two's-complement numbers.
- R6: The unsigned relations compare A with the 16-bit negation of B, both taken as unsigned numbers.
- R7: Condition bit 0 inverts the selected relation, so code 1 never branches and each odd code gives the complement of the even code below it.
- R8: The target is the advanced PC plus twice the sign-extended displacement plus 2, wrapped modulo 2^16.
- R9: A taken branch reports 2 extra cycles and a not-taken branch reports 0. In any cycle not following a branch strobe, `br_taken` is 0 and `br_extra` is 0.
- R10: Results appear on the outputs in the cycle after the branch strobe. A branch whose strobe coincides with a capture strobe is evaluated on the operands held before that capture.
- R11: While reset is applied, `br_taken`, `br_target` and `br_extra` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Stores the operand pair at this edge |
| cap_a | input | 16 | Left adder operand |
| cap_b | input | 16 | Right adder operand (negated for subtract) |
| br_en | input | 1 | A branch executes in this cycle |
| br_cond | input | 4 | Condition code: relation select in [3:1], invert in [0] |
| br_disp | input | 8 | Signed displacement in instruction words |
| br_pc | input | 16 | Program counter already advanced past the branch |
| br_taken | output | 1 | Branch taken |
| br_target | output | 16 | Destination address |
| br_extra | output | 2 | Extra cycles charged to this branch |

## Verification
A capture at one edge is visible to any branch strobed at a later edge, and a branch's three results are registered once, so they are due exactly one clock after the strobe. The bench drives inputs on falling edges, lets one rising edge pass and samples on the next falling edge, which is the single cycle in which the registered result stands. After each sweep step it samples one more falling edge to confirm that taken and extra drop back to zero, and it places a capture and a branch in the same cycle to confirm the branch sees the older pair.

// File: rtl/brc_pkg.sv
package brc_pkg;

    // Relation selected by condition bits [3:1]
    typedef enum logic [2:0] {
        REL_ALWAYS = 3'd0,
        REL_EQ     = 3'd1,
        REL_CARRY  = 3'd2,
        REL_OVFL   = 3'd3,
        REL_LT     = 3'd4,
        REL_LE     = 3'd5,
        REL_LTU    = 3'd6,
        REL_LEU    = 3'd7
    } rel_kind_e;

    typedef struct packed {
        rel_kind_e kind;
        logic      invert;
    } cond_code_t;

    localparam int COND_W = 4;

    function automatic cond_code_t split_cond(input logic [COND_W-1:0] c);
        cond_code_t r;
        r.kind   = rel_kind_e'(c[COND_W-1:1]);
        r.invert = c[0];
        return r;
    endfunction

endpackage

// File: rtl/brc_operand_latch.sv
module brc_operand_latch #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] cap_a,
    input  logic [DATA_W-1:0] cap_b,
    output logic [DATA_W-1:0] opa_q,
    output logic [DATA_W-1:0] opb_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            opa_q <= '0;
            opb_q <= '0;
        end else if (cap_en) begin
            opa_q <= cap_a;
            opb_q <= cap_b;
        end
    end

    AST_PAIR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> ($stable(opa_q) && $stable(opb_q)));                     // R1
    AST_PAIR_LOADS: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> (opa_q == $past(cap_a) && opb_q == $past(cap_b)));        // R1

endmodule

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
    import brc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [COND_W-1:0] cond,
    output logic              hit
);

    localparam int MSB = DATA_W - 1;

    cond_code_t        cc;
    logic [DATA_W:0]   wide_sum;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] negb;
    logic              carry, ovfl, eq, slt, ult, rel;

    always_comb begin
        cc       = split_cond(cond);
        wide_sum = {1'b0, opa} + {1'b0, opb};
        sum      = wide_sum[MSB:0];
        negb     = '0 - opb;
        carry    = wide_sum[DATA_W];
        ovfl     = (opa[MSB] ^ sum[MSB]) & (opb[MSB] ^ sum[MSB]);
        eq       = (opa == negb);
        slt      = ($signed(opa) < $signed(negb));
        ult      = (opa < negb);
        unique case (cc.kind)
            REL_ALWAYS: rel = 1'b1;
            REL_EQ:     rel = eq;
            REL_CARRY:  rel = carry;
            REL_OVFL:   rel = ovfl;
            REL_LT:     rel = slt;
            REL_LE:     rel = slt | eq;
            REL_LTU:    rel = ult;
            REL_LEU:    rel = ult | eq;
            default:    rel = 1'b0;
        endcase
        hit = rel ^ cc.invert;
    end

    always_comb begin
        AST_CARRY_RULE: assert (carry == ((sum < opa) || (sum < opb)));   // R3
        AST_OVFL_RULE: assert (ovfl ==
            ((opa[MSB] == opb[MSB]) && (sum[MSB] != opa[MSB])));          // R4
    end

endmodule

// File: rtl/brc_target_gen.sv
module brc_target_gen #(
    parameter int DATA_W = 16,
    parameter int DISP_W = 8
) (
    input  logic [DATA_W-1:0] pc_next,
    input  logic [DISP_W-1:0] disp,
    output logic [DATA_W-1:0] target
);

    localparam int EXT_W = DATA_W - DISP_W;

    logic [DATA_W-1:0] disp_ext;
    logic [DATA_W-1:0] disp_bytes;

    always_comb begin
        disp_ext   = {{EXT_W{disp[DISP_W-1]}}, disp};
        disp_bytes = disp_ext << 1;
        target     = pc_next + disp_bytes + DATA_W'(2);
    end

endmodule

// File: rtl/brc_unit.sv
module brc_unit
    import brc_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int DISP_W  = 8,
    parameter int PENALTY = 2,
    localparam int EXTRA_W = $clog2(PENALTY + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cap_en,
    input  logic [DATA_W-1:0]  cap_a,
    input  logic [DATA_W-1:0]  cap_b,
    input  logic               br_en,
    input  logic [COND_W-1:0]  br_cond,
    input  logic [DISP_W-1:0]  br_disp,
    input  logic [DATA_W-1:0]  br_pc,
    output logic               br_taken,
    output logic [DATA_W-1:0]  br_target,
    output logic [EXTRA_W-1:0] br_extra
);

    logic [DATA_W-1:0] opa_q, opb_q;
    logic              hit;
    logic [DATA_W-1:0] tgt;

    brc_operand_latch #(.DATA_W(DATA_W)) u_latch (
        .clk    (clk),
        .rst    (rst),
        .cap_en (cap_en),
        .cap_a  (cap_a),
        .cap_b  (cap_b),
        .opa_q  (opa_q),
        .opb_q  (opb_q)
    );

    brc_cond_eval #(.DATA_W(DATA_W)) u_eval (
        .opa  (opa_q),
        .opb  (opb_q),
        .cond (br_cond),
        .hit  (hit)
    );

    brc_target_gen #(.DATA_W(DATA_W), .DISP_W(DISP_W)) u_tgt (
        .pc_next (br_pc),
        .disp    (br_disp),
        .target  (tgt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            br_taken  <= 1'b0;
            br_target <= '0;
            br_extra  <= '0;
        end else begin
            br_taken <= br_en & hit;
            br_extra <= (br_en & hit) ? EXTRA_W'(PENALTY) : '0;
            if (br_en)
                br_target <= tgt;
        end
    end

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !br_en |=> (!br_taken && br_extra == '0));                          // R9
    AST_ALWAYS_TAKES: assert property (@(posedge clk) disable iff (rst)
        (br_en && br_cond == '0) |=> br_taken);                             // R7
    AST_NEVER_TAKES: assert property (@(posedge clk) disable iff (rst)
        (br_en && br_cond == COND_W'(1)) |=> !br_taken);                    // R7
    AST_EXTRA_PAIRS: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> br_extra == EXTRA_W'(PENALTY));                        // R9

endmodule

// File: tb/tb_brc_unit.sv
module tb_brc_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cap_en;
    logic [15:0] cap_a, cap_b;
    logic        br_en;
    logic [3:0]  br_cond;
    logic [7:0]  br_disp;
    logic [15:0] br_pc;
    logic        br_taken;
    logic [15:0] br_target;
    logic [1:0]  br_extra;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brc_unit dut (
        .clk(clk), .rst(rst), .cap_en(cap_en), .cap_a(cap_a), .cap_b(cap_b),
        .br_en(br_en), .br_cond(br_cond), .br_disp(br_disp), .br_pc(br_pc),
        .br_taken(br_taken), .br_target(br_target), .br_extra(br_extra)
    );

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic bit ref_hit(input int a, input int b, input int c);
        int nb, sum, sa, snb;
        bit r;
        nb  = (65536 - b) % 65536;
        sum = a + b;
        sa  = (a >= 32768) ? a - 65536 : a;
        snb = (nb >= 32768) ? nb - 65536 : nb;
        case (c / 2)
            0: r = 1;
            1: r = (a == nb);
            2: r = (sum > 65535);
            3: r = ((a >= 32768) == (b >= 32768)) &&
                   (((sum % 65536) >= 32768) != (a >= 32768));
            4: r = (sa < snb);
            5: r = (sa <= snb);
            6: r = (a < nb);
            default: r = (a <= nb);
        endcase
        return r ^ bit'(c % 2);
    endfunction

    function automatic int ref_target(input int pc, input int d);
        int sd;
        sd = (d >= 128) ? d - 256 : d;
        return (pc + 2 * sd + 2 + 65536 * 4) % 65536;
    endfunction

    function automatic string req_of(input int c);
        case (c / 2)
            0, 1: return (c % 2) ? "R7" : "R2";
            2: return "R3";
            3: return "R4";
            4, 5: return "R5";
            default: return "R6";
        endcase
    endfunction

    // called at a falling edge, returns at the next falling edge
    task automatic capture(input int a, input int b);
        cap_en = 1; cap_a = 16'(a); cap_b = 16'(b);
        @(negedge clk);
        cap_en = 0;
    endtask

    task automatic branch_check(input int a, input int b, input int c,
                                input int d, input int pc, input bit idle);
        bit exp_t;
        br_en = 1; br_cond = 4'(c); br_disp = 8'(d); br_pc = 16'(pc);
        @(negedge clk);
        br_en = 0;
        exp_t = ref_hit(a, b, c);
        check(req_of(c), int'(br_taken), int'(exp_t));
        check("R8", int'(br_target), ref_target(pc, d));
        check("R9", int'(br_extra), exp_t ? 2 : 0);
        if (idle) begin
            @(negedge clk);
            check("R9", int'(br_taken), 0);
            check("R9", int'(br_extra), 0);
        end
    endtask

    int vals [8] = '{0, 1, 2, 16'h7FFF, 16'h8000, 16'h8001, 16'hFFFF, 16'h1234};

    initial begin
        rst = 1; cap_en = 0; cap_a = 0; cap_b = 0;
        br_en = 0; br_cond = 0; br_disp = 0; br_pc = 0;
        repeat (3) @(negedge clk);
        check("R11", int'(br_taken), 0);
        check("R11", int'(br_target), 0);
        check("R11", int'(br_extra), 0);
        rst = 0;

        // R1: pair resets to zero, so equal holds and carry does not
        branch_check(0, 0, 2, 0, 16'h0100, 1);
        branch_check(0, 0, 4, 0, 16'h0100, 0);

        // R1 hold: value stays across idle cycles
        capture(5, 16'hFFFB);
        repeat (4) @(negedge clk);
        branch_check(5, 16'hFFFB, 2, 3, 16'h0200, 0);

        // R10: capture coincident with branch uses older pair
        cap_en = 1; cap_a = 16'h0003; cap_b = 16'h0003;
        br_en = 1; br_cond = 4'd2; br_disp = 0; br_pc = 16'h0040;
        @(negedge clk);
        cap_en = 0; br_en = 0;
        check("R10", int'(br_taken), 1);
        branch_check(3, 3, 2, 0, 16'h0040, 0);
        check("R10", int'(br_taken), 0);

        // near-exhaustive sweep of conditions over corner operand pairs
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                capture(vals[i], vals[j]);
                for (int c = 0; c < 16; c++)
                    branch_check(vals[i], vals[j], c, (c * 37 + i) % 256,
                                 (i * 8191 + j * 4099) % 65536, (c == 15));
            end
        end

        // R8: every displacement, with wrap at both ends
        capture(0, 0);
        for (int d = 0; d < 256; d++) begin
            branch_check(0, 0, 0, d, 16'hFFF0, 0);
            branch_check(0, 0, 0, d, 16'h0010, 0);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++; n_errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule